// File: doc/BRIEF.md
# UART Receive Line Status with Error-Tagged FIFO

This block holds received characters for a 16550-style UART and builds the eight-bit line status byte that the CPU reads. Each character that the receive deserializer completes arrives with three indications: parity error, framing error and break. The character and its three tags are stored together as one entry of a receive FIFO. The status byte shows the tags of the entry at the head of the FIFO. A summary bit stays set while any stored entry is still tagged. An overrun flag records a character that arrived while there was no room for it.

The block also follows how many characters the transmit side holds, though it stores no transmit data. It counts the holding register or transmit FIFO, and it tracks whether the shift register is busy. From these it derives the holding-empty and transmitter-empty status bits. The CPU pops receive data by asserting `rx_read`, writes transmit data by asserting `tx_write`, and reads the status with `lsr_read`. Simple strobes stand in for the transmit serializer: `tx_load` means the shift register takes a character, and `tx_shift_done` means it has finished sending.

A small state machine filters break frames so that a long break loads only one entry. It has two states. In `BRK_IDLE`, a completed character is stored; if it carries the break tag, the transition "break seen" moves the machine to `BRK_HELD`. In `BRK_HELD`, further break-tagged frames are discarded and the state holds. A completed character without the break tag is stored, and the transition "line recovered" returns the machine to `BRK_IDLE`.

Top module: `uart_lsr_fifo`

## Requirements
- R1: After reset, both FIFOs are empty and the status byte reads 8'h60: bits 6 and 5 are 1 and every other bit is 0.
- R2: Status bit 0 (data ready) is 1 while the receive store holds at least one character. `rx_dout` always presents the oldest stored character, and each `rx_read` removes it, so characters leave in arrival order.
- R3: Status bit 4 (break), bit 3 (framing) and bit 2 (parity) show the tags of the head entry only. They move to the tags of the next entry on each `rx_read`, and they read 0 while the store is empty.
- R4: Status bit 7 is 1 while any stored entry carries at least one tag, and it is 0 once none does. It stays correct when a tagged entry is pushed and a tagged head is popped in the same cycle.
- R5: A character that completes while the store is full, with no pop in that cycle, is discarded. Status bit 1 (overrun) is then set, and the stored entries and their order are unchanged.
- R6: A cycle with `lsr_read` high clears the overrun bit from the next cycle, unless a new overrun happens in that same cycle.
- R7: While the break filter is in `BRK_HELD`, further completed break-tagged characters are not stored. The next character without the break tag is stored, and a break after it is stored again.
- R8: With `fifo_en` low, the receive store and the transmit holding store each hold one character. A second received character then overruns (R5). A second transmit write before a load is ignored.
- R9: Status bit 5 is 1 exactly when the transmit holding store is empty. It goes to 0 from the cycle after a `tx_write`. It goes to 1 from the cycle after the `tx_load` that removes the last held character. With `fifo_en` high, the store holds 16 characters.
- R10: Status bit 6 is 1 only when the transmit holding store is empty and the shift register is idle. `tx_load` makes the shift register busy. `tx_shift_done` makes it idle, and `tx_load` is ignored while the shift register is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = FIFO mode (depth 16), 0 = single holding register |
| rx_valid | input | 1 | One-cycle strobe: a character has completed |
| rx_data | input | 8 | Completed character |
| rx_perr | input | 1 | Parity-error tag of the completed character |
| rx_ferr | input | 1 | Framing-error tag of the completed character |
| rx_brk | input | 1 | Break tag of the completed character |
| rx_read | input | 1 | CPU pop of the receive data register |
| rx_dout | output | 8 | Head character (0 when empty) |
| lsr_read | input | 1 | CPU read of the status byte |
| lsr | output | 8 | Status byte, bits 7..0: error summary, transmitter empty, holding empty, break, framing, parity, overrun, data ready |
| tx_write | input | 1 | CPU write to the transmit holding store |
| tx_load | input | 1 | Shift register takes one held character |
| tx_shift_done | input | 1 | Shift register has finished its character |

## Verification
The hardest case to reach from the ports is the error summary while tags come and go in the middle of the store. To reach it, the stimulus fills the store from a table of tagged and untagged characters. It then pops the entries one at a time, comparing bit 7 with whether any tagged entry remains, and includes a cycle where a tagged push and a tagged pop happen together. The overrun case fills all sixteen entries and then sends a seventeenth character. Popping everything afterwards shows that the original sixteen characters are still in order. The break case sends several break frames in a row before a normal character and checks that only one break entry was stored.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [0:0] {
        BRK_IDLE = 1'b0,
        BRK_HELD = 1'b1
    } brk_state_t;

    function automatic logic entry_tagged(rx_entry_t e);
        return e.brk | e.ferr | e.perr;
    endfunction
endpackage

// File: rtl/uart_brk_filter.sv
module uart_brk_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  logic rx_brk,
    output logic push_ok
);
    import uart_lsr_pkg::*;

    brk_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BRK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        push_ok = 1'b0;
        unique case (state_q)
            BRK_IDLE: begin
                push_ok = rx_valid;
                if (rx_valid && rx_brk) state_d = BRK_HELD;
            end
            BRK_HELD: begin
                push_ok = rx_valid && !rx_brk;
                if (rx_valid && !rx_brk) state_d = BRK_IDLE;
            end
            default: state_d = BRK_IDLE;
        endcase
    end

    assert_brk_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && rx_brk) |=> (state_q == BRK_HELD));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DEPTH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fifo_en,
    input  logic                    push,
    input  uart_lsr_pkg::rx_entry_t push_entry,
    input  logic                    pop,
    output uart_lsr_pkg::rx_entry_t head,
    output logic                    not_empty,
    output logic                    err_any,
    output logic                    drop
);
    import uart_lsr_pkg::*;

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   count, err_cnt, cap;
    logic            full, do_pop, accept, inc_err, dec_err;

    assign cap       = fifo_en ? CW'(DEPTH) : CW'(1);
    assign full      = (count >= cap);
    assign not_empty = (count != '0);
    assign do_pop    = pop && not_empty;
    assign accept    = push && (!full || do_pop);
    assign drop      = push && !accept;
    assign head      = mem[rd_ptr];
    assign inc_err   = accept && entry_tagged(push_entry);
    assign dec_err   = do_pop && entry_tagged(head);
    assign err_any   = (err_cnt != '0);

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            err_cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (accept) begin
                mem[wr_ptr] <= push_entry;
                wr_ptr      <= bump(wr_ptr);
            end
            if (do_pop) rd_ptr <= bump(rd_ptr);
            count   <= count + CW'(accept) - CW'(do_pop);
            err_cnt <= err_cnt + CW'(inc_err) - CW'(dec_err);
        end
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_err_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= count);
    assert_full_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count) && $stable(wr_ptr));
endmodule

// File: rtl/uart_tx_track.sv
module uart_tx_track #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_en,
    input  logic wr,
    input  logic load,
    input  logic done,
    output logic hold_empty,
    output logic all_empty
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] count, cap;
    logic          busy, do_load, wr_ok;

    assign cap        = fifo_en ? CW'(DEPTH) : CW'(1);
    assign do_load    = load && (count != '0) && (!busy || done);
    assign wr_ok      = wr && ((count < cap) || do_load);
    assign hold_empty = (count == '0);
    assign all_empty  = hold_empty && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            busy  <= 1'b0;
        end else begin
            count <= count + CW'(wr_ok) - CW'(do_load);
            if (do_load)   busy <= 1'b1;
            else if (done) busy <= 1'b0;
        end
    end

    assert_last_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy && !wr && count == CW'(1)) |=> (hold_empty && !all_empty));
    assert_write_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hold_empty) |=> !hold_empty);
endmodule

// File: rtl/uart_lsr_fifo.sv
module uart_lsr_fifo #(
    parameter int RX_DEPTH = 16,
    parameter int TX_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_perr,
    input  logic       rx_ferr,
    input  logic       rx_brk,
    input  logic       rx_read,
    output logic [7:0] rx_dout,
    input  logic       lsr_read,
    output logic [7:0] lsr,
    input  logic       tx_write,
    input  logic       tx_load,
    input  logic       tx_shift_done
);
    import uart_lsr_pkg::*;

    rx_entry_t in_entry, head;
    logic      push_ok, not_empty, err_any, ovr_drop, ovr_q;
    logic      hold_empty, all_empty;

    assign in_entry = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_data};

    uart_brk_filter u_brk (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_brk   (rx_brk),
        .push_ok  (push_ok)
    );

    uart_rx_fifo #(.DEPTH(RX_DEPTH)) u_rxq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .push       (push_ok),
        .push_entry (in_entry),
        .pop        (rx_read),
        .head       (head),
        .not_empty  (not_empty),
        .err_any    (err_any),
        .drop       (ovr_drop)
    );

    uart_tx_track #(.DEPTH(TX_DEPTH)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .wr         (tx_write),
        .load       (tx_load),
        .done       (tx_shift_done),
        .hold_empty (hold_empty),
        .all_empty  (all_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ovr_q <= 1'b0;
        else if (ovr_drop) ovr_q <= 1'b1;
        else if (lsr_read) ovr_q <= 1'b0;
    end

    assign rx_dout = not_empty ? head.data : '0;
    assign lsr = {err_any, all_empty, hold_empty,
                  not_empty & head.brk, not_empty & head.ferr, not_empty & head.perr,
                  ovr_q, not_empty};

    assert_oe_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_read && !ovr_drop) |=> !lsr[1]);
    assert_oe_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_drop |=> lsr[1] && $stable(rx_dout));
    assert_temt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[6] |-> lsr[5]);
endmodule

// File: tb/uart_lsr_fifo_tb_top.sv
`timescale 1ns/1ps
module uart_lsr_fifo_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic       rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_read = 1'b0, lsr_read = 1'b0;
    logic       tx_write = 1'b0, tx_load = 1'b0, tx_shift_done = 1'b0;
    logic [7:0] rx_dout, lsr;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    uart_lsr_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_read(rx_read),
        .rx_dout(rx_dout), .lsr_read(lsr_read), .lsr(lsr),
        .tx_write(tx_write), .tx_load(tx_load), .tx_shift_done(tx_shift_done)
    );

    // {brk, ferr, perr, data}
    localparam logic [10:0] VEC [6] = '{
        {3'b000, 8'hA1}, {3'b001, 8'hB2}, {3'b000, 8'hC3},
        {3'b010, 8'hD4}, {3'b100, 8'h00}, {3'b000, 8'hE5}
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic mode);
        fifo_en = mode;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(logic [7:0] d, logic b, logic f, logic p);
        rx_valid = 1'b1; rx_data = d; rx_brk = b; rx_ferr = f; rx_perr = p;
        @(negedge clk);
        rx_valid = 1'b0; rx_brk = 1'b0; rx_ferr = 1'b0; rx_perr = 1'b0;
    endtask

    task automatic pop();
        rx_read = 1'b1;
        @(negedge clk);
        rx_read = 1'b0;
    endtask

    task automatic strobe_tx(logic w, logic l, logic d);
        tx_write = w; tx_load = l; tx_shift_done = d;
        @(negedge clk);
        tx_write = 1'b0; tx_load = 1'b0; tx_shift_done = 1'b0;
    endtask

    initial begin
        do_reset(1'b1);
        check("R1 reset status", lsr, 8'h60);
        check("R1 reset dout", rx_dout, 8'h00);

        // table walk
        foreach (VEC[i]) push(VEC[i][7:0], VEC[i][10], VEC[i][9], VEC[i][8]);
        check("R2 ready after pushes", {7'd0, lsr[0]}, 8'd1);
        for (int i = 0; i < 6; i++) begin
            logic any;
            any = 1'b0;
            for (int j = i; j < 6; j++) any |= |VEC[j][10:8];
            check("R2 head data", rx_dout, VEC[i][7:0]);
            check("R3 head tags", {5'd0, lsr[4:2]}, {5'd0, VEC[i][10:8]});
            check("R4 summary", {7'd0, lsr[7]}, {7'd0, any});
            pop();
        end
        check("R2 empty after pops", lsr, 8'h60);

        // same-cycle tagged push and tagged pop
        push(8'h11, 1'b0, 1'b1, 1'b0);
        rx_read = 1'b1;
        push(8'h22, 1'b0, 1'b0, 1'b1);
        rx_read = 1'b0;
        check("R4 summary after swap", {7'd0, lsr[7]}, 8'd1);
        check("R3 swap head", rx_dout, 8'h22);
        pop();
        check("R4 summary cleared", {7'd0, lsr[7]}, 8'd0);

        // overrun
        for (int i = 0; i < 16; i++) push(8'h10 + 8'(i), 1'b0, 1'b0, 1'b0);
        check("R5 no overrun when just full", {7'd0, lsr[1]}, 8'd0);
        push(8'hEE, 1'b0, 1'b0, 1'b1);
        check("R5 overrun set", {7'd0, lsr[1]}, 8'd1);
        check("R5 dropped char untagged store", {7'd0, lsr[7]}, 8'd0);
        lsr_read = 1'b1;
        @(negedge clk);
        lsr_read = 1'b0;
        check("R6 overrun cleared by status read", {7'd0, lsr[1]}, 8'd0);
        for (int i = 0; i < 16; i++) begin
            check("R5 contents intact", rx_dout, 8'h10 + 8'(i));
            pop();
        end
        check("R5 nothing extra stored", {7'd0, lsr[0]}, 8'd0);

        // break filter
        push(8'h00, 1'b1, 1'b1, 1'b0);
        push(8'h00, 1'b1, 1'b1, 1'b0);
        push(8'h00, 1'b1, 1'b1, 1'b0);
        push(8'h55, 1'b0, 1'b0, 1'b0);
        push(8'h00, 1'b1, 1'b0, 1'b0);
        check("R7 first break head", {5'd0, lsr[4:2]}, 8'b110);
        pop();
        check("R7 one break entry", rx_dout, 8'h55);
        check("R7 normal char no break", {7'd0, lsr[4]}, 8'd0);
        pop();
        check("R7 break after recovery stored", {7'd0, lsr[4]}, 8'd1);
        pop();
        check("R7 store empty", {7'd0, lsr[0]}, 8'd0);

        // transmit tracking, FIFO mode
        strobe_tx(1'b1, 1'b0, 1'b0);
        check("R9 write clears holding empty", lsr[6:5], 2'b00);
        strobe_tx(1'b0, 1'b1, 1'b0);
        check("R10 shift busy after load", lsr[6:5], 2'b01);
        strobe_tx(1'b0, 1'b0, 1'b1);
        check("R10 transmitter empty after done", lsr[6:5], 2'b11);
        strobe_tx(1'b1, 1'b0, 1'b0);
        strobe_tx(1'b1, 1'b0, 1'b0);
        strobe_tx(1'b0, 1'b1, 1'b0);
        check("R9 one left in FIFO", {7'd0, lsr[5]}, 8'd0);
        strobe_tx(1'b0, 1'b1, 1'b0);
        check("R10 load ignored while busy", {7'd0, lsr[5]}, 8'd0);
        strobe_tx(1'b0, 1'b0, 1'b1);
        strobe_tx(1'b0, 1'b1, 1'b0);
        check("R9 FIFO empty after last load", lsr[6:5], 2'b01);
        strobe_tx(1'b0, 1'b0, 1'b1);

        // non-FIFO mode
        do_reset(1'b0);
        check("R1 reset status non-FIFO", lsr, 8'h60);
        push(8'h3C, 1'b0, 1'b0, 1'b0);
        push(8'h4D, 1'b0, 1'b0, 1'b0);
        check("R8 second char overruns", {7'd0, lsr[1]}, 8'd1);
        check("R8 holding keeps first", rx_dout, 8'h3C);
        pop();
        check("R8 holding empty", {7'd0, lsr[0]}, 8'd0);
        strobe_tx(1'b1, 1'b0, 1'b0);
        strobe_tx(1'b1, 1'b0, 1'b0);
        strobe_tx(1'b0, 1'b1, 1'b0);
        check("R8 second tx write ignored", lsr[6:5], 2'b01);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule